// File: doc/BRIEF.md
# Eight-bit shift and rotate unit

This block is the shift/rotate slice of an accumulator-style datapath. Given one operand byte, a two-bit operation code and the present condition-code bits (negative, zero, overflow, carry), it returns the shifted byte and the condition-code bits the instruction would leave behind. Three operations are supported: rotate left through carry, rotate right through carry, and arithmetic shift right. A fourth code forwards the operand and every incoming flag untouched.

The block holds no state and has no clock. The surrounding core places the operand and flags on the inputs and takes the result and new flags in the same cycle. Opcode decoding, write-back, memory operands and the half-carry bit belong to the core.

Top module: `shift_rotate_unit`

## Requirements
- R1: With op_i = 2'b00 (rotate left), result_o equals operand bits 6..0 shifted up one place with c_i inserted at bit 0.
- R2: With op_i = 2'b00, c_o equals operand bit 7 and v_o equals operand bit 7 XOR operand bit 6.
- R3: With op_i = 2'b01 (rotate right), result_o carries c_i in bit 7 and operand bits 7..1 in bits 6..0, and c_o equals operand bit 0.
- R4: With op_i = 2'b01, v_o equals v_i.
- R5: With op_i = 2'b10 (arithmetic shift right), result_o bit 7 equals operand bit 7, bits 6..0 equal operand bits 7..1, and c_o equals operand bit 0; c_i has no effect on result_o.
- R6: With op_i = 2'b10, v_o equals v_i, so a clear overflow flag stays clear.
- R7: For op_i in 2'b00, 2'b01 and 2'b10, n_o equals result_o bit 7 and z_o is 1 exactly when result_o is 8'h00.
- R8: With op_i = 2'b11, result_o equals the operand and n_o, z_o, v_o, c_o equal n_i, z_i, v_i, c_i, with no flag recomputed from the operand.
- R9: All outputs follow the inputs without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 8 | Source byte |
| op_i | input | 2 | Operation: 00 rotate left, 01 rotate right, 10 arithmetic shift right, 11 pass-through |
| n_i | input | 1 | Incoming negative flag |
| z_i | input | 1 | Incoming zero flag |
| v_i | input | 1 | Incoming overflow flag |
| c_i | input | 1 | Incoming carry flag |
| result_o | output | 8 | Shifted or rotated byte |
| n_o | output | 1 | Next negative flag |
| z_o | output | 1 | Next zero flag |
| v_o | output | 1 | Next overflow flag |
| c_o | output | 1 | Next carry flag |

## Verification
The interesting overlap is carry-in and carry-out acting in the same operation: a rotate both consumes c_i at one end and produces c_o from the other, and the zero flag then depends on whether the inserted carry is the only set bit. The bench provokes this with operands such as 8'h80 and 8'h01 under both carry-in values, where the rotated-out bit and the inserted bit decide between a zero and non-zero result, and it judges the result byte, zero flag and carry together against a model built from arithmetic rather than bit slicing. The full sweep over every operand, both carry states and both overflow states for each operation code covers the remaining combinations, including pass-through with flags that contradict the operand.

// File: rtl/shift_rotate_pkg.sv
package shift_rotate_pkg;

  typedef enum logic [1:0] {
    OP_ROL  = 2'b00,
    OP_ROR  = 2'b01,
    OP_ASR  = 2'b10,
    OP_PASS = 2'b11
  } sr_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } sr_flags_t;

endpackage

// File: rtl/sr_rotate.sv
// Rotate through carry by one place; LEFT picks the direction.
module sr_rotate #(
  parameter int unsigned W    = 8,
  parameter bit          LEFT = 1'b1
) (
  input  logic [W-1:0] src_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);

  generate
    if (LEFT) begin : g_left
      assign res_o  = {src_i[W-2:0], cin_i};
      assign cout_o = src_i[W-1];
    end else begin : g_right
      assign res_o  = {cin_i, src_i[W-1:1]};
      assign cout_o = src_i[0];
    end
  endgenerate

endmodule

// File: rtl/sr_asr.sv
// Arithmetic shift right by one: sign bit replicated.
module sr_asr #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] src_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);

  assign res_o  = {src_i[W-1], src_i[W-1:1]};
  assign cout_o = src_i[0];

endmodule

// File: rtl/sr_nz.sv
// Sign and zero detection on a result word.
module sr_nz #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] res_i,
  output logic         n_o,
  output logic         z_o
);

  assign n_o = res_i[W-1];
  assign z_o = ~|res_i;

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import shift_rotate_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] operand_i,
  input  logic [1:0]   op_i,
  input  logic         n_i,
  input  logic         z_i,
  input  logic         v_i,
  input  logic         c_i,
  output logic [W-1:0] result_o,
  output logic         n_o,
  output logic         z_o,
  output logic         v_o,
  output logic         c_o
);

  localparam int unsigned MSB = W - 1;

  sr_op_e      op;
  logic [W-1:0] rol_res, ror_res, asr_res;
  logic         rol_c, ror_c, asr_c;
  logic         calc_n, calc_z;
  sr_flags_t    flags;

  assign op = sr_op_e'(op_i);

  sr_rotate #(.W(W), .LEFT(1'b1)) u_rol (
    .src_i (operand_i),
    .cin_i (c_i),
    .res_o (rol_res),
    .cout_o(rol_c)
  );

  sr_rotate #(.W(W), .LEFT(1'b0)) u_ror (
    .src_i (operand_i),
    .cin_i (c_i),
    .res_o (ror_res),
    .cout_o(ror_c)
  );

  sr_asr #(.W(W)) u_asr (
    .src_i (operand_i),
    .res_o (asr_res),
    .cout_o(asr_c)
  );

  always_comb begin
    unique case (op)
      OP_ROL:  result_o = rol_res;
      OP_ROR:  result_o = ror_res;
      OP_ASR:  result_o = asr_res;
      default: result_o = operand_i;
    endcase
  end

  sr_nz #(.W(W)) u_nz (
    .res_i(result_o),
    .n_o  (calc_n),
    .z_o  (calc_z)
  );

  always_comb begin
    flags = '{n: n_i, z: z_i, v: v_i, c: c_i};
    unique case (op)
      OP_ROL: begin
        flags.n = calc_n;
        flags.z = calc_z;
        // overflow when the sign changes on the way out
        flags.v = operand_i[MSB] ^ operand_i[MSB-1];
        flags.c = rol_c;
      end
      OP_ROR: begin
        flags.n = calc_n;
        flags.z = calc_z;
        flags.c = ror_c;
      end
      OP_ASR: begin
        flags.n = calc_n;
        flags.z = calc_z;
        flags.c = asr_c;
      end
      default: ;
    endcase
  end

  assign n_o = flags.n;
  assign z_o = flags.z;
  assign v_o = flags.v;
  assign c_o = flags.c;

endmodule

// File: rtl/shift_rotate_unit_chk.sv
module shift_rotate_unit_chk #(
  parameter int unsigned W = 8
) (
  input logic [W-1:0] operand_i,
  input logic [1:0]   op_i,
  input logic         n_i,
  input logic         z_i,
  input logic         v_i,
  input logic         c_i,
  input logic [W-1:0] result_o,
  input logic         n_o,
  input logic         z_o,
  input logic         v_o,
  input logic         c_o
);

  logic known;
  assign known = !$isunknown({operand_i, op_i, n_i, z_i, v_i, c_i});

  always_comb begin
    if (known) begin
      if (op_i == 2'b00) begin
        AST_ROL_CARRY_IN:  assert (result_o[0] == c_i);                  // R1
        AST_ROL_FLAGS:     assert (c_o == operand_i[W-1] &&
                                   v_o == (result_o[W-1] ^ c_o));       // R2
      end
      if (op_i == 2'b01) begin
        AST_ROR_ENDS:      assert (result_o[W-1] == c_i && c_o == operand_i[0]); // R3
        AST_ROR_V_HOLD:    assert (v_o == v_i);                          // R4
      end
      if (op_i == 2'b10) begin
        AST_ASR_SIGN:      assert (result_o[W-1] == result_o[W-2] &&
                                   result_o[W-1] == operand_i[W-1]);    // R5
        AST_ASR_V_HOLD:    assert (v_o == v_i);                          // R6
      end
      if (op_i != 2'b11) begin
        AST_ZERO_NOT_NEG:  assert (!(z_o && n_o));                      // R7
      end
      if (op_i == 2'b11) begin
        AST_PASS_ALL:      assert (result_o == operand_i &&
                                   {n_o, z_o, v_o, c_o} == {n_i, z_i, v_i, c_i}); // R8
      end
    end
  end

endmodule

bind shift_rotate_unit shift_rotate_unit_chk #(.W(W)) u_chk (
  .operand_i(operand_i),
  .op_i     (op_i),
  .n_i      (n_i),
  .z_i      (z_i),
  .v_i      (v_i),
  .c_i      (c_i),
  .result_o (result_o),
  .n_o      (n_o),
  .z_o      (z_o),
  .v_o      (v_o),
  .c_o      (c_o)
);

// File: tb/tb_shift_rotate_unit.sv
`timescale 1ns/1ps
module tb_shift_rotate_unit;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] operand_i = '0;
  logic [1:0] op_i = '0;
  logic       n_i = 1'b0, z_i = 1'b0, v_i = 1'b0, c_i = 1'b0;
  logic [7:0] result_o;
  logic       n_o, z_o, v_o, c_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  shift_rotate_unit dut (
    .operand_i(operand_i), .op_i(op_i),
    .n_i(n_i), .z_i(z_i), .v_i(v_i), .c_i(c_i),
    .result_o(result_o), .n_o(n_o), .z_o(z_o), .v_o(v_o), .c_o(c_o)
  );

  // {op, c, v, n, z, operand, exp_res, exp_n, exp_z, exp_v, exp_c}
  localparam int NV = 10;
  localparam logic [25:0] VEC [NV] = '{
    {2'b00, 4'b0000, 8'h80, 8'h00, 4'b0111},  // R1 R2: only bit rotates out
    {2'b00, 4'b1000, 8'h40, 8'h81, 4'b1010},  // R1 R2
    {2'b00, 4'b1000, 8'hC0, 8'h81, 4'b1001},  // R2 no overflow
    {2'b01, 4'b0100, 8'h01, 8'h00, 4'b0111},  // R3 R4 R7
    {2'b01, 4'b1000, 8'h02, 8'h81, 4'b1000},  // R3
    {2'b10, 4'b1000, 8'h81, 8'hC0, 4'b1001},  // R5: carry-in ignored
    {2'b10, 4'b0100, 8'h01, 8'h00, 4'b0111},  // R5 R6
    {2'b10, 4'b0000, 8'h7E, 8'h3F, 4'b0000},  // R5 R6
    {2'b11, 4'b1010, 8'h00, 8'h00, 4'b1001},  // R8: flags not recomputed
    {2'b11, 4'b0101, 8'hFF, 8'hFF, 4'b0110}   // R8
  };

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h (op=%0d opnd=%02h c=%0b v=%0b)",
               req, what, act, exp, op_i, operand_i, c_i, v_i);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [7:0] opnd,
                       input logic n, input logic z, input logic v, input logic c);
    op_i = op; operand_i = opnd; n_i = n; z_i = z; v_i = v; c_i = c;
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // reset state: all-zero inputs, rotate left gives zero
    apply(2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7", "reset result", result_o, 8'h00);
    chk("R7", "reset z", {7'd0, z_o}, 8'd1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [25:0] e;
      e = VEC[i];
      apply(e[25:24], e[19:12], e[21], e[20], e[22], e[23]);
      chk("R1R3R5R8", "tbl result", result_o, e[11:4]);
      chk("R7R8", "tbl n", {7'd0, n_o}, {7'd0, e[3]});
      chk("R7R8", "tbl z", {7'd0, z_o}, {7'd0, e[2]});
      chk("R2R4R6", "tbl v", {7'd0, v_o}, {7'd0, e[1]});
      chk("R2R3R5", "tbl c", {7'd0, c_o}, {7'd0, e[0]});
    end

    // R9: output follows input between clock edges
    @(posedge clk);
    apply(2'b01, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9", "no-clock result", result_o, 8'hD5);
    apply(2'b01, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9", "no-clock result 2", result_o, 8'h2A);
    @(negedge clk);

    // full sweep against an arithmetic model
    for (int op = 0; op < 4; op++)
      for (int cv = 0; cv < 4; cv++)
        for (int x = 0; x < 256; x++) begin
          int er, ec, ev, en, ez;
          int c, v, fn, fz;
          c = cv & 1; v = cv >> 1;
          fn = (x + cv) & 1; fz = ((x >> 3) ^ cv) & 1;
          apply(op[1:0], x[7:0], fn[0], fz[0], v[0], c[0]);
          case (op)
            0: begin
              er = (x * 2 + c) % 256; ec = x / 128;
              ev = ((x / 128) + (x / 64)) % 2;
            end
            1: begin
              er = x / 2 + c * 128; ec = x % 2; ev = v;
            end
            2: begin
              er = (x >= 128) ? (x / 2 + 128) : x / 2; ec = x % 2; ev = v;
            end
            default: begin
              er = x; ec = c; ev = v;
            end
          endcase
          if (op == 3) begin
            en = fn; ez = fz;
          end else begin
            en = (er >= 128) ? 1 : 0; ez = (er == 0) ? 1 : 0;
          end
          if (op == 0) begin
            chk("R1", "rol result", result_o, er[7:0]);
            chk("R2", "rol c", {7'd0, c_o}, ec[7:0]);
            chk("R2", "rol v", {7'd0, v_o}, ev[7:0]);
          end else if (op == 1) begin
            chk("R3", "ror result", result_o, er[7:0]);
            chk("R3", "ror c", {7'd0, c_o}, ec[7:0]);
            chk("R4", "ror v", {7'd0, v_o}, ev[7:0]);
          end else if (op == 2) begin
            chk("R5", "asr result", result_o, er[7:0]);
            chk("R5", "asr c", {7'd0, c_o}, ec[7:0]);
            chk("R6", "asr v", {7'd0, v_o}, ev[7:0]);
          end else begin
            chk("R8", "pass result", result_o, er[7:0]);
            chk("R8", "pass c", {7'd0, c_o}, ec[7:0]);
            chk("R8", "pass v", {7'd0, v_o}, ev[7:0]);
          end
          chk("R7", "n", {7'd0, n_o}, en[7:0]);
          chk("R7", "z", {7'd0, z_o}, ez[7:0]);
        end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule